// File: doc/BRIEF.md
# Stereo PDM Microphone Front End

This block connects a pair of digital microphones that share a single one-bit data line. It acts as bit-clock master: it divides the system clock down to 128 bit-clock periods per audio frame. It takes one microphone's bit just before each rising edge and the other microphone's bit just before each falling edge. Each captured bit is classed as a pulse or a non-pulse by a selectable level sense. The bit is then routed to the left or right channel, and the edge-to-channel mapping can be swapped.

Each channel turns its one-bit stream into signed 16-bit PCM with a third-order integrator-comb decimator. Every 128 bit periods the channel emits one sample with a single-cycle valid strobe. The two channels can be enabled independently, and an output inversion negates the samples. A frame-rate strobe sets the phase: once the microphone path is selected, the bit clock starts on the next frame strobe. Changes to level sense, swap and inversion are held back until the next decimation boundary.

Top module: `stereo_pdm_frontend`

## Requirements
- R1: While running, `mic_bclk` is driven by the block and toggles every HALF_DIV system clocks. With the default HALF_DIV = 2, rising edges are 4 clocks apart.
- R2: While `mic_sel` is 0, `mic_bclk` is held low one clock later and neither valid strobe fires. After `mic_sel` goes to 1, the bit clock stays low until the first cycle in which `frame_stb` is high, and starts after it.
- R3: With `ch_swap` = 0, the bit sampled one system clock before a rising edge of `mic_bclk` belongs to the left channel, and the bit before a falling edge belongs to the right channel.
- R4: With `ch_swap` = 1, the mapping is reversed: the rising-edge bits belong to the right channel and the falling-edge bits to the left.
- R5: With `pol_high` = 0, a low data level counts as a pulse. With `pol_high` = 1, a high level counts as a pulse.
- R6: `ch_en[0]` enables left and `ch_en[1]` enables right, so 00 = none, 01 = left only, 10 = right only and 11 = both. A channel whose enable bit is 0 never raises its valid strobe.
- R7: With `out_inv` = 1, each sample is the negation of the non-inverted filter result, saturated to 16 bits. With `out_inv` = 0 it passes unchanged.
- R8: A pulse counts +1 and a non-pulse −1. The sample is the third-order comb output over 128-bit decimation (full scale ±2^21), times −1 when inverted, arithmetically shifted right by 6 and saturated to [−32768, 32767]. In steady state: all pulses give 32767, no pulses give −32768, three pulses in four give 16384, one in two gives 0 and one in four gives −16384.
- R9: Each enabled channel raises its valid strobe for exactly one cycle every 128 bit-clock periods. When both channels run, the two strobes coincide. The sample output holds its value between strobes.
- R10: A channel's filter is cleared while it is inactive. After a start, the first sample appears after three full decimation periods, that is, with 384 rising edges seen. A channel enabled mid-run starts at the next boundary, so its first sample coincides with the other channel's fourth sample after the enable.
- R11: A change to `pol_high`, `ch_swap` or `out_inv` takes effect only at the next decimation boundary. The sample emitted at that boundary still reflects the old settings entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 × 128 × fS |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle frame-rate strobe that phases the start |
| mic_sel | input | 1 | Selects and runs the microphone path |
| pol_high | input | 1 | Pulse level sense: 0 = low is pulse, 1 = high is pulse |
| ch_swap | input | 1 | Swaps the edge-to-channel mapping |
| out_inv | input | 1 | Negates the output samples |
| ch_en | input | 2 | Channel enables, bit 0 left, bit 1 right |
| mic_data | input | 1 | Shared interleaved PDM data line |
| mic_bclk | output | 1 | Bit clock driven to the microphones |
| pcm_left | output | 16 | Left signed PCM sample |
| pcm_right | output | 16 | Right signed PCM sample |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_vld | output | 1 | One-cycle strobe for a new right sample |

## Verification
The bench drives a model microphone pair whose rising-edge and falling-edge bits follow different density patterns. If the swap or the level sense were applied wrongly, the channels would trade values or flip sign instead of matching the computed levels. Separate checks cover the saturated extremes, the inversion of a full-scale negative level, and a disabled channel that must stay silent. Start-up is timed by counting bit-clock rising edges, so filling too little or too long shows as a count other than 384, and an enable made mid-period must wait for a boundary. Level sense, swap and inversion are changed in the middle of a period: a design that applied them at once would corrupt the very next sample instead of leaving it untouched.

// File: rtl/spdm_pkg.sv
package spdm_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } spdm_edge_e;

   typedef struct packed {
      logic pol_high;
      logic swap;
      logic inv;
   } spdm_ctrl_t;

   function automatic int cic_growth(input int order, input int dec_log2);
      return order * dec_log2;
   endfunction

endpackage

// File: rtl/spdm_bclk_gen.sv
module spdm_bclk_gen
   import spdm_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int DEC_LOG2 = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mic_sel,
   input  logic       frame_stb,
   output logic       bclk,
   output logic       run,
   output logic       start_stb,
   output logic       smp_stb,
   output spdm_edge_e smp_edge,
   output logic       bnd_stb
);

   localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
   localparam logic [DIV_W-1:0] DIV_SMP  = DIV_W'(HALF_DIV - 2);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("spdm_bclk_gen: HALF_DIV must be 2 or more");
      end
      if (DEC_LOG2 < 1) begin : g_bad_dec
         $error("spdm_bclk_gen: DEC_LOG2 must be 1 or more");
      end
   endgenerate

   logic [DIV_W-1:0]    div_q;
   logic [DEC_LOG2-1:0] slot_q;
   logic                bnd_q;
   logic                live;

   assign live      = run & mic_sel;
   assign start_stb = mic_sel & frame_stb & ~run;

   always_ff @(posedge clk) begin
      if (!rst_n)          run <= 1'b0;
      else if (!mic_sel)   run <= 1'b0;
      else if (frame_stb)  run <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !live)       div_q <= '0;
      else if (div_q == DIV_LAST) div_q <= '0;
      else                        div_q <= div_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !live)        bclk <= 1'b0;
      else if (div_q == DIV_LAST) bclk <= ~bclk;
   end

   assign smp_stb  = live & (div_q == DIV_SMP);
   assign smp_edge = bclk ? EDGE_FALL : EDGE_RISE;

   always_ff @(posedge clk) begin
      if (!rst_n || !live)    slot_q <= '0;
      else if (smp_stb && bclk) slot_q <= slot_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !live) bnd_q <= 1'b0;
      else                 bnd_q <= smp_stb & bclk & (&slot_q);
   end

   assign bnd_stb = bnd_q & live;

endmodule

// File: rtl/spdm_cic.sv
module spdm_cic
   import spdm_pkg::*;
#(
   parameter int ORDER    = 3,
   parameter int DEC_LOG2 = 7,
   parameter int OUT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             smp_stb,
   input  logic             smp_pulse,
   input  logic             dump_stb,
   input  logic             invert,
   output logic [OUT_W-1:0] pcm,
   output logic             vld
);

   localparam int GROW   = cic_growth(ORDER, DEC_LOG2);
   localparam int ACC_W  = GROW + 2;
   localparam int SHIFT  = GROW - (OUT_W - 1);
   localparam int FILL_W = $clog2(ORDER + 1);
   localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(ORDER);
   localparam logic [FILL_W-1:0] FILL_EMIT = FILL_W'(ORDER - 1);
   localparam logic signed [ACC_W:0] PCM_MAX = (ACC_W + 1)'((2 ** (OUT_W - 1)) - 1);
   localparam logic signed [ACC_W:0] PCM_MIN = -PCM_MAX - 1;

   generate
      if (ORDER < 1) begin : g_bad_order
         $error("spdm_cic: ORDER must be 1 or more");
      end
      if (SHIFT < 0) begin : g_bad_shift
         $error("spdm_cic: OUT_W too wide for the filter growth");
      end
   endgenerate

   logic signed [ACC_W-1:0] x_in;
   assign x_in = {{(ACC_W - 1){~smp_pulse}}, 1'b1};

   genvar g;
   generate
      for (g = 0; g < ORDER; g++) begin : g_int
         logic signed [ACC_W-1:0] acc_q;
         logic signed [ACC_W-1:0] acc_d;
         logic signed [ACC_W-1:0] feed;
         if (g == 0) begin : g_head
            assign feed = x_in;
         end else begin : g_tail
            assign feed = g_int[g-1].acc_d;
         end
         assign acc_d = acc_q + feed;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) acc_q <= '0;
            else if (smp_stb)      acc_q <= acc_d;
         end
      end

      for (g = 0; g < ORDER; g++) begin : g_comb
         logic signed [ACC_W-1:0] dly_q;
         logic signed [ACC_W-1:0] src;
         logic signed [ACC_W-1:0] diff;
         if (g == 0) begin : g_head
            assign src = g_int[ORDER-1].acc_q;
         end else begin : g_tail
            assign src = g_comb[g-1].diff;
         end
         assign diff = src - dly_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) dly_q <= '0;
            else if (dump_stb)     dly_q <= src;
         end
      end
   endgenerate

   logic signed [ACC_W:0] full_x;
   logic signed [ACC_W:0] signd;
   logic signed [ACC_W:0] scaled;
   logic signed [ACC_W:0] clipped;
   logic [FILL_W-1:0]     fill_q;
   logic                  emit;

   assign full_x  = (ACC_W + 1)'(g_comb[ORDER-1].diff);
   assign signd   = invert ? -full_x : full_x;
   assign scaled  = signd >>> SHIFT;
   assign clipped = (scaled > PCM_MAX) ? PCM_MAX :
                    (scaled < PCM_MIN) ? PCM_MIN : scaled;
   assign emit    = active & dump_stb & (fill_q >= FILL_EMIT);

   always_ff @(posedge clk) begin
      if (!rst_n || !active)                   fill_q <= '0;
      else if (dump_stb && fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcm <= '0;
         vld <= 1'b0;
      end else begin
         vld <= emit;
         if (emit) pcm <= clipped[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/stereo_pdm_frontend.sv
module stereo_pdm_frontend
   import spdm_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int DEC_LOG2 = 7,
   parameter int ORDER    = 3,
   parameter int OUT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb,
   input  logic             mic_sel,
   input  logic             pol_high,
   input  logic             ch_swap,
   input  logic             out_inv,
   input  logic [1:0]       ch_en,
   input  logic             mic_data,
   output logic             mic_bclk,
   output logic [OUT_W-1:0] pcm_left,
   output logic [OUT_W-1:0] pcm_right,
   output logic             left_vld,
   output logic             right_vld
);

   localparam int NCH = 2;

   logic       run;
   logic       start_stb;
   logic       smp_stb;
   spdm_edge_e smp_edge;
   logic       bnd_stb;
   logic       period_start;
   spdm_ctrl_t ctrl_q;
   logic       smp_pulse;

   logic [NCH-1:0]   armed_q;
   logic [NCH-1:0]   active;
   logic [NCH-1:0]   ch_smp;
   logic [OUT_W-1:0] pcm_ch [NCH];
   logic [NCH-1:0]   vld_ch;

   spdm_bclk_gen #(
      .HALF_DIV (HALF_DIV),
      .DEC_LOG2 (DEC_LOG2)
   ) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .mic_sel   (mic_sel),
      .frame_stb (frame_stb),
      .bclk      (mic_bclk),
      .run       (run),
      .start_stb (start_stb),
      .smp_stb   (smp_stb),
      .smp_edge  (smp_edge),
      .bnd_stb   (bnd_stb)
   );

   assign period_start = start_stb | bnd_stb;

   always_ff @(posedge clk) begin
      if (!rst_n)            ctrl_q <= '0;
      else if (period_start) ctrl_q <= '{pol_high: pol_high, swap: ch_swap, inv: out_inv};
   end

   assign smp_pulse = (mic_data == ctrl_q.pol_high);

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         localparam logic IS_RIGHT = (c == 1);

         assign ch_smp[c] = smp_stb & ((smp_edge == EDGE_RISE) ^ ctrl_q.swap ^ IS_RIGHT);
         assign active[c] = armed_q[c] & ch_en[c] & mic_sel & run;

         always_ff @(posedge clk) begin
            if (!rst_n || !mic_sel || !ch_en[c]) armed_q[c] <= 1'b0;
            else if (period_start)               armed_q[c] <= 1'b1;
         end

         spdm_cic #(
            .ORDER    (ORDER),
            .DEC_LOG2 (DEC_LOG2),
            .OUT_W    (OUT_W)
         ) u_cic (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (active[c]),
            .smp_stb   (ch_smp[c]),
            .smp_pulse (smp_pulse),
            .dump_stb  (bnd_stb),
            .invert    (ctrl_q.inv),
            .pcm       (pcm_ch[c]),
            .vld       (vld_ch[c])
         );
      end
   endgenerate

   assign pcm_left  = pcm_ch[0];
   assign pcm_right = pcm_ch[1];
   assign left_vld  = vld_ch[0];
   assign right_vld = vld_ch[1];

endmodule

// File: rtl/spdm_frontend_chk.sv
module spdm_frontend_chk #(
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mic_sel,
   input logic [1:0]       ch_en,
   input logic             mic_bclk,
   input logic [OUT_W-1:0] pcm_left,
   input logic [OUT_W-1:0] pcm_right,
   input logic             left_vld,
   input logic             right_vld
);

   // R1: a high phase of the bit clock lasts at least two system clocks
   assert_bclk_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mic_bclk) && mic_sel) |=> mic_bclk);

   // R2: deselection parks the bit clock low
   assert_bclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mic_sel |=> !mic_bclk);

   // R2: deselection silences both channels
   assert_no_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mic_sel |=> (!left_vld && !right_vld));

   // R6: a disabled left channel stays silent
   assert_left_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[0] |=> !left_vld);

   // R6: a disabled right channel stays silent
   assert_right_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[1] |=> !right_vld);

   // R9: valid strobes last a single cycle
   assert_vld_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (left_vld || right_vld) |=> (!left_vld && !right_vld));

   // R9: samples hold between strobes
   assert_pcm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!left_vld && !right_vld) |-> ($stable(pcm_left) && $stable(pcm_right)));

endmodule

bind stereo_pdm_frontend spdm_frontend_chk #(.OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mic_sel   (mic_sel),
   .ch_en     (ch_en),
   .mic_bclk  (mic_bclk),
   .pcm_left  (pcm_left),
   .pcm_right (pcm_right),
   .left_vld  (left_vld),
   .right_vld (right_vld)
);

// File: tb/stereo_pdm_frontend_bench.sv
`timescale 1ns/1ps
module stereo_pdm_frontend_bench;

   localparam int HALF   = 2;
   localparam int PERIOD = 2 * HALF * 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_stb = 1'b0;
   logic        mic_sel = 1'b0;
   logic        pol_high = 1'b0;
   logic        ch_swap = 1'b0;
   logic        out_inv = 1'b0;
   logic [1:0]  ch_en = 2'b00;
   logic        mic_data = 1'b0;
   logic        mic_bclk;
   logic [15:0] pcm_left;
   logic [15:0] pcm_right;
   logic        left_vld;
   logic        right_vld;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int last_rise = 0;
   int rise_gap = 0;
   bit finished = 1'b0;
   logic [3:0] rise_lv = 4'b0000;
   logic [3:0] fall_lv = 4'b0000;
   logic [7:0] bslot = 8'd0;

   always #4 clk = ~clk;

   stereo_pdm_frontend #(.HALF_DIV(HALF)) u_stereo_pdm_frontend (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mic_sel(mic_sel),
      .pol_high(pol_high), .ch_swap(ch_swap), .out_inv(out_inv), .ch_en(ch_en),
      .mic_data(mic_data), .mic_bclk(mic_bclk), .pcm_left(pcm_left),
      .pcm_right(pcm_right), .left_vld(left_vld), .right_vld(right_vld)
   );

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   initial forever begin
      @(posedge mic_bclk);
      rise_gap  = cyc - last_rise;
      last_rise = cyc;
      rise_cnt++;
   end

   // model microphone pair: new bit driven just after each bit-clock edge
   initial forever begin
      @(mic_bclk);
      if (mic_bclk) mic_data = fall_lv[bslot[1:0]];
      else begin
         bslot    = bslot + 8'd1;
         mic_data = rise_lv[bslot[1:0]];
      end
   end

   // {pol, swap, inv, en[1:0], rise levels[3:0], fall levels[3:0]}
   localparam logic [12:0] VEC [8] = '{
      {1'b1, 1'b0, 1'b0, 2'b11, 4'b1111, 4'b0000},
      {1'b1, 1'b1, 1'b0, 2'b11, 4'b1111, 4'b0000},
      {1'b0, 1'b0, 1'b0, 2'b11, 4'b0111, 4'b0101},
      {1'b1, 1'b0, 1'b1, 2'b11, 4'b0111, 4'b0001},
      {1'b1, 1'b0, 1'b0, 2'b01, 4'b1111, 4'b0111},
      {1'b1, 1'b0, 1'b0, 2'b10, 4'b0000, 4'b0111},
      {1'b0, 1'b1, 1'b1, 2'b11, 4'b0000, 4'b0001},
      {1'b1, 1'b0, 1'b1, 2'b00, 4'b1111, 4'b1111}
   };

   function automatic int expect_pcm(input bit pol, input bit inv, input logic [3:0] lv);
      int ones;
      int v;
      ones = pol ? $countones(lv) : 4 - $countones(lv);
      v = 8192 * (2 * ones - 4);
      if (inv) v = -v;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start_run();
      mic_sel = 1'b1;
      repeat (3) @(negedge clk);
      rise_cnt  = 0;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   task automatic stop_run();
      mic_sel = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic next_left(output int v, output int edges);
      int n;
      v = 0;
      edges = 0;
      for (n = 0; n < 4 * PERIOD; n++) begin
         @(negedge clk);
         if (left_vld) begin
            v = $signed(pcm_left);
            edges = rise_cnt;
            break;
         end
      end
   endtask

   task automatic run_vec(input int idx);
      logic [12:0] w;
      int nl, nr, l1, l2, r1, r2, le1, le2, re1, mism;
      int el, er;
      w = VEC[idx];
      stop_run();
      pol_high = w[12]; ch_swap = w[11]; out_inv = w[10]; ch_en = w[9:8];
      rise_lv  = w[7:4]; fall_lv = w[3:0];
      mic_data = rise_lv[bslot[1:0]];
      start_run();
      nl = 0; nr = 0; l1 = 0; l2 = 0; r1 = 0; r2 = 0; le1 = 0; le2 = 0; re1 = 0; mism = 0;
      for (int n = 0; n < 5 * PERIOD; n++) begin
         @(negedge clk);
         if (left_vld) begin
            nl++;
            if (nl == 1) begin l1 = $signed(pcm_left); le1 = rise_cnt; end
            if (nl == 2) begin l2 = $signed(pcm_left); le2 = rise_cnt; end
         end
         if (right_vld) begin
            nr++;
            if (nr == 1) begin r1 = $signed(pcm_right); re1 = rise_cnt; end
            if (nr == 2) r2 = $signed(pcm_right);
         end
         if (ch_en == 2'b11 && left_vld != right_vld) mism++;
      end
      // R3 R4 route by edge and swap, R5 level sense, R7 inversion, R8 scaling
      el = expect_pcm(w[12], w[10], w[11] ? fall_lv : rise_lv);
      er = expect_pcm(w[12], w[10], w[11] ? rise_lv : fall_lv);
      if (w[8]) begin
         chk(nl >= 2, "R9 left strobes per period", nl, 2);
         chk(l1 == el, "R3/R4/R5/R7/R8 left sample", l1, el);
         chk(l2 == el, "R8 left steady sample", l2, el);
         chk(le1 == 384, "R10 left fill edges", le1, 384);
         chk(le2 - le1 == 128, "R9 left interval edges", le2 - le1, 128);
      end else begin
         chk(nl == 0, "R6 left disabled", nl, 0);
      end
      if (w[9]) begin
         chk(nr >= 2, "R9 right strobes per period", nr, 2);
         chk(r1 == er, "R3/R4/R5/R7/R8 right sample", r1, er);
         chk(r2 == er, "R8 right steady sample", r2, er);
         chk(re1 == 384, "R10 right fill edges", re1, 384);
      end else begin
         chk(nr == 0, "R6 right disabled", nr, 0);
      end
      if (w[9:8] == 2'b11) chk(mism == 0, "R9 strobes coincide", mism, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int v, e, cnt, seen;
      repeat (4) @(negedge clk);
      // reset state (R2)
      chk(mic_bclk == 1'b0, "R2 reset bclk", mic_bclk, 0);
      chk(left_vld == 1'b0 && right_vld == 1'b0, "R2 reset valid", left_vld, 0);
      chk(pcm_left == 16'd0, "R2 reset pcm", pcm_left, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      for (int i = 0; i < 8; i++) run_vec(i);

      // R2: selected but waiting for a frame strobe
      stop_run();
      pol_high = 1'b1; ch_swap = 1'b0; out_inv = 1'b0; ch_en = 2'b11;
      rise_lv = 4'b0111; fall_lv = 4'b0111;
      mic_sel = 1'b1;
      cnt = 0;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         if (mic_bclk) cnt++;
      end
      chk(cnt == 0, "R2 waits for frame strobe", cnt, 0);
      rise_cnt  = 0;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      repeat (40) @(negedge clk);
      chk(rise_cnt > 0, "R2 starts after frame strobe", rise_cnt, 1);
      chk(rise_gap == 2 * HALF, "R1 bit clock period", rise_gap, 2 * HALF);

      // R11: level sense changed mid-period
      next_left(v, e);
      repeat (200) @(negedge clk);
      pol_high = 1'b0;
      next_left(v, e);
      chk(v == 16384, "R11 old level sense at boundary", v, 16384);
      next_left(v, e); next_left(v, e); next_left(v, e);
      chk(v == -16384, "R11 new level sense settled", v, -16384);

      // R11: inversion changed mid-period
      repeat (200) @(negedge clk);
      out_inv = 1'b1;
      next_left(v, e);
      chk(v == -16384, "R11 old inversion at boundary", v, -16384);
      next_left(v, e);
      chk(v == 16384, "R7 R11 new inversion next sample", v, 16384);

      // R11: swap changed mid-period
      stop_run();
      pol_high = 1'b1; out_inv = 1'b0; ch_swap = 1'b0;
      rise_lv = 4'b1111; fall_lv = 4'b0000;
      start_run();
      next_left(v, e);
      repeat (200) @(negedge clk);
      ch_swap = 1'b1;
      next_left(v, e);
      chk(v == 32767, "R11 old swap at boundary", v, 32767);
      next_left(v, e); next_left(v, e); next_left(v, e);
      chk(v == -32768, "R4 R11 new swap settled", v, -32768);

      // R10: right enabled mid-run joins at a boundary
      stop_run();
      ch_swap = 1'b0; ch_en = 2'b01;
      rise_lv = 4'b1111; fall_lv = 4'b0111;
      start_run();
      next_left(v, e);
      repeat (200) @(negedge clk);
      ch_en = 2'b11;
      cnt = 0; seen = 0; v = 0;
      for (int n = 0; n < 6 * PERIOD && seen == 0; n++) begin
         @(negedge clk);
         if (left_vld) cnt++;
         if (right_vld) begin seen = 1; v = $signed(pcm_right); end
      end
      chk(cnt == 4, "R10 mid-run enable waits for boundary", cnt, 4);
      chk(v == 16384, "R10 first right sample after enable", v, 16384);

      // R2: deselect mid-run
      repeat (100) @(negedge clk);
      mic_sel = 1'b0;
      repeat (2) @(negedge clk);
      cnt = 0;
      for (int n = 0; n < 3 * PERIOD; n++) begin
         @(negedge clk);
         if (mic_bclk || left_vld || right_vld) cnt++;
      end
      chk(cnt == 0, "R2 deselect idles clock and strobes", cnt, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule